// File: doc/BRIEF.md
# Glitch-Free Coefficient Safeload Unit

This block lets a host replace a small group of DSP coefficients without the audio datapath ever reading a half-updated set. The host stages up to five 32-bit words, plus a destination pointer and a word count, through a plain address/data/write-strobe control port. The staged values stay put until a valid count is written. That write arms the unit. On the next frame-start strobe the unit copies the staged words, one per beat, into consecutive locations of the parameter RAM.

The control map has the data slots at control addresses 1 through 5, the destination pointer at 6 and the count at 7. The pointer holds the target RAM address minus one, so word 1 lands at pointer + 1. The RAM write side is a valid/ready stream. The unit raises `ram_wvalid` with an address and data and holds all three unchanged until the RAM accepts the beat with `ram_wready`. One word is accepted per cycle in which both are high. The RAM may stall for any number of cycles. The unit never withdraws or changes a beat it has offered. `busy` is a plain status pin. While it is high, every host write is dropped.

Top module: `param_safeload`

## Requirements
- R1: After reset `busy` and `ram_wvalid` are low.
- R2: A write to control address 1..5 stores a 32-bit word in slot 1..5. Slot k supplies the data of the k-th RAM beat of a copy.
- R3: Control address 6 stores the RAM address minus one. Beat k (k = 1..N) goes to (stored + k) modulo 2^PADDR_W, which is 1024 locations by default.
- R4: A write of a value from 1 to 5 to control address 7 arms the unit, and `busy` is high from the next cycle.
- R5: A write of 0, or of any value above 5, to control address 7 is ignored. `busy` stays low and no RAM beat follows a frame strobe.
- R6: No RAM beat is offered while the unit is armed and waiting. A frame strobe in the same cycle as the arming write does not start the copy. The first beat is offered in the cycle after a strobe is seen in the armed state.
- R7: A copy offers exactly N beats. `busy` and `ram_wvalid` are low in the cycle after the last beat is accepted.
- R8: While `ram_wvalid` is high and `ram_wready` is low, `ram_wvalid`, `ram_waddr` and `ram_wdata` hold their values into the next cycle.
- R9: Host writes to any control address while `busy` is high are dropped. Staged slots and the pointer keep their values, and a later count write alone copies them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_addr | input | CADDR_W | Control address |
| ctl_wdata | input | DATA_W | Control write data |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| busy | output | 1 | Copy pending or in progress |
| ram_wvalid | output | 1 | RAM write beat offered |
| ram_wready | input | 1 | RAM accepts the offered beat |
| ram_waddr | output | PADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |

## Verification
The bench sweeps every legal count against pointers at 0, mid-range, and the top two RAM locations, with and without a stalling RAM. A design that mishandled the wrap or the plus-one offset would write to the wrong locations. One that dropped a beat under stall would shift data by one. It also offers every illegal count value class and a frame strobe coincident with arming. A wrong design would respond by copying stray words, or by starting a copy before the next frame. Finally it hammers the control port while busy and then re-arms with a count alone. A design that let those writes through would copy the new values instead of the staged ones.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_ARMED = 2'd1,
    SL_COPY  = 2'd2
  } sl_state_e;
endpackage

// File: rtl/safeload_stage.sv
module safeload_stage #(
  parameter int NSLOT     = 5,
  parameter int DATA_W    = 32,
  parameter int CADDR_W   = 16,
  parameter int PADDR_W   = 10,
  parameter int SLOT_BASE = 1,
  localparam int IDX_W    = $clog2(NSLOT + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [CADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          busy,
  output logic [NSLOT-1:0][DATA_W-1:0]  slots,
  output logic [PADDR_W-1:0]            base,
  output logic [IDX_W-1:0]              count,
  output logic                          arm
);
  localparam int PTR_REG = SLOT_BASE + NSLOT;
  localparam int CNT_REG = PTR_REG + 1;

  logic accept, count_ok;
  assign accept   = wr_en && !busy;
  assign count_ok = (wr_data != '0) && (wr_data <= DATA_W'(NSLOT));
  assign arm      = accept && (wr_addr == CADDR_W'(CNT_REG)) && count_ok;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slots[g] <= '0;
      else if (accept && wr_addr == CADDR_W'(SLOT_BASE + g)) slots[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      count <= '0;
    end else begin
      if (accept && wr_addr == CADDR_W'(PTR_REG)) base <= wr_data[PADDR_W-1:0];
      if (arm) count <= wr_data[IDX_W-1:0];
    end
  end

  assert_busy_drops_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(slots) && $stable(base) && $stable(count)));
endmodule

// File: rtl/safeload_copy.sv
module safeload_copy
  import safeload_pkg::*;
#(
  parameter int NSLOT   = 5,
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 10,
  localparam int IDX_W  = $clog2(NSLOT + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm,
  input  logic                          frame_start,
  input  logic [NSLOT-1:0][DATA_W-1:0]  slots,
  input  logic [PADDR_W-1:0]            base,
  input  logic [IDX_W-1:0]              count,
  output logic                          wvalid,
  input  logic                          wready,
  output logic [PADDR_W-1:0]            waddr,
  output logic [DATA_W-1:0]             wdata,
  output logic                          busy
);
  sl_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             last;

  assign wvalid = (state == SL_COPY);
  assign busy   = (state != SL_IDLE);
  assign waddr  = base + PADDR_W'(1) + PADDR_W'(idx);
  assign wdata  = slots[idx];
  assign last   = (idx == count - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SL_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        SL_IDLE:  if (arm) state <= SL_ARMED;
        SL_ARMED: if (frame_start) begin
          state <= SL_COPY;
          idx   <= '0;
        end
        SL_COPY:  if (wready) begin
          if (last) state <= SL_IDLE;
          idx <= idx + IDX_W'(1);
        end
        default:  state <= SL_IDLE;
      endcase
    end
  end

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(waddr) && $stable(wdata)));

  assert_start_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wvalid) |-> $past(frame_start));

  assert_consecutive_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready) |=> (!wvalid || waddr == $past(waddr) + PADDR_W'(1)));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready && last) |=> !busy);
endmodule

// File: rtl/param_safeload.sv
module param_safeload #(
  parameter int NSLOT     = 5,
  parameter int DATA_W    = 32,
  parameter int CADDR_W   = 16,
  parameter int PADDR_W   = 10,
  parameter int SLOT_BASE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [CADDR_W-1:0] ctl_addr,
  input  logic [DATA_W-1:0]  ctl_wdata,
  input  logic               frame_start,
  output logic               busy,
  output logic               ram_wvalid,
  input  logic               ram_wready,
  output logic [PADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0]  ram_wdata
);
  localparam int IDX_W   = $clog2(NSLOT + 1);
  localparam int CNT_REG = SLOT_BASE + NSLOT + 1;

  logic [NSLOT-1:0][DATA_W-1:0] slots;
  logic [PADDR_W-1:0]           base;
  logic [IDX_W-1:0]             count;
  logic                         arm;

  safeload_stage #(
    .NSLOT(NSLOT), .DATA_W(DATA_W), .CADDR_W(CADDR_W),
    .PADDR_W(PADDR_W), .SLOT_BASE(SLOT_BASE)
  ) i_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_addr(ctl_addr),
    .wr_data(ctl_wdata), .busy(busy), .slots(slots), .base(base),
    .count(count), .arm(arm)
  );

  safeload_copy #(
    .NSLOT(NSLOT), .DATA_W(DATA_W), .PADDR_W(PADDR_W)
  ) i_copy (
    .clk(clk), .rst_n(rst_n), .arm(arm), .frame_start(frame_start),
    .slots(slots), .base(base), .count(count), .wvalid(ram_wvalid),
    .wready(ram_wready), .waddr(ram_waddr), .wdata(ram_wdata), .busy(busy)
  );

  assert_valid_count_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy && ctl_addr == CADDR_W'(CNT_REG) &&
     ctl_wdata != '0 && ctl_wdata <= DATA_W'(NSLOT)) |=> busy);

  assert_bad_count_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy && ctl_addr == CADDR_W'(CNT_REG) &&
     (ctl_wdata == '0 || ctl_wdata > DATA_W'(NSLOT))) |=> !busy);

  assert_beat_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wvalid |-> busy);
endmodule

// File: tb/test_param_safeload.sv
module test_param_safeload;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;
  logic        frame_start = 1'b0;
  logic        busy, ram_wvalid;
  logic        ram_wready = 1'b1;
  logic [9:0]  ram_waddr;
  logic [31:0] ram_wdata;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_slot [5];
  logic [9:0]  exp_base = '0;
  int          exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  param_safeload i_param_safeload (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .frame_start(frame_start), .busy(busy),
    .ram_wvalid(ram_wvalid), .ram_wready(ram_wready),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d, input bit fs = 1'b0);
    @(negedge clk);
    if (!busy) begin
      if (a >= 1 && a <= 5) exp_slot[a-1] = d;
      if (a == 6) exp_base = d[9:0];
      if (a == 7 && d >= 1 && d <= 5) exp_cnt = int'(d);
    end
    ctl_wr = 1'b1; ctl_addr = 16'(a); ctl_wdata = d; frame_start = fs;
    @(negedge clk);
    ctl_wr = 1'b0; frame_start = 1'b0;
  endtask

  task automatic run_copy(input int n, input bit stall);
    int k = 0;
    int cyc = 0;
    bit held = 0;
    logic [9:0] h_addr;
    logic [31:0] h_data;
    for (int w = 0; w < 3; w++) begin
      check(ram_wvalid == 1'b0, "R6 no beat before frame", 32'(ram_wvalid), 0);
      @(negedge clk);
    end
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    while (k < n && cyc < 60) begin
      ram_wready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (held) begin
        check(ram_wvalid && ram_waddr == h_addr && ram_wdata == h_data,
              "R8 beat held under stall", ram_wdata, h_data);
        held = 0;
      end
      if (ram_wvalid && ram_wready) begin
        check(ram_waddr == exp_base + 10'(k + 1), "R3 beat address",
              32'(ram_waddr), 32'(exp_base + 10'(k + 1)));
        check(ram_wdata == exp_slot[k], "R2 beat data", ram_wdata, exp_slot[k]);
        k++;
      end else if (ram_wvalid) begin
        held = 1; h_addr = ram_waddr; h_data = ram_wdata;
      end
      cyc++;
      @(negedge clk);
    end
    ram_wready = 1'b1;
    check(k == n, "R7 beat count", 32'(k), 32'(n));
    check(!busy && !ram_wvalid, "R7 idle after last beat", {30'b0, busy, ram_wvalid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [9:0] bases [4];
    logic [31:0] bad [4];
    bases[0] = 10'h000; bases[1] = 10'h155; bases[2] = 10'h3FD; bases[3] = 10'h3FF;
    bad[0] = 32'd0; bad[1] = 32'd6; bad[2] = 32'd7; bad[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 5; i++) exp_slot[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !ram_wvalid, "R1 reset state", {30'b0, busy, ram_wvalid}, 0);

    for (int b = 0; b < 4; b++)
      for (int n = 1; n <= 5; n++)
        for (int s = 0; s < 2; s++) begin
          for (int k = 0; k < n; k++)
            host_write(k + 1, 32'h5A00_0000 ^ (32'(b) << 16) ^ (32'(n) << 8) ^ 32'(k * 17 + s));
          host_write(6, 32'(bases[b]));
          host_write(7, 32'(n));
          check(busy == 1'b1, "R4 armed after count write", 32'(busy), 1);
          run_copy(n, s[0]);
        end

    for (int i = 0; i < 4; i++) begin
      host_write(7, bad[i]);
      check(busy == 1'b0, "R5 bad count ignored", 32'(busy), 0);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      check(!ram_wvalid && !busy, "R5 no beat after bad count", 32'(ram_wvalid), 0);
    end

    for (int k = 0; k < 5; k++) host_write(k + 1, 32'hC0DE_0000 + 32'(k));
    host_write(6, 32'h010);
    host_write(7, 32'd2);
    host_write(1, 32'hDEAD_BEEF);
    host_write(2, 32'hDEAD_BEEF);
    host_write(6, 32'h200);
    host_write(7, 32'd5);
    run_copy(2, 1'b0);
    host_write(7, 32'd5);
    check(exp_base == 10'h010, "R9 pointer kept", 32'(exp_base), 32'h010);
    run_copy(5, 1'b1);

    host_write(7, 32'd3, 1'b1);
    check(busy == 1'b1, "R6 armed despite coincident strobe", 32'(busy), 1);
    run_copy(3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule